// File: doc/BRIEF.md
# Timed-Sample Packet Framer

The framer takes time-stamped sample entries from an upstream queue and turns them into framed packets on a 36-bit word stream. Each entry holds a 64-bit time, two flag bits and up to `MAXCH` 32-bit channel samples. A packet starts with a header word, then the stream identifier and the two halves of the time stamp of the packet's first entry. The samples follow, one word per active channel per entry, and a trailer word closes the packet. The header template, stream identifier, trailer template, entries per packet and active channel count come from a small write-only settings port.

Packets are assembled in an internal circular buffer. The header slot is reserved when a packet starts and filled in last, once the true word count is known. Only then does the packet become visible at the output. A packet is closed early when an entry carries the burst-end flag, or when an error entry arrives. An error entry produces a one-word packet that is marked as both start and end. The buffer reports how many words it holds, whether it has room for another maximum-size packet, and whether any complete word is waiting. A synchronous clear discards the buffer contents and any partly built packet. `DEPTH` must be a power of two and at least 5 + MAX_SPP*MAXCH.

Top module: `tsamp_framer`

## Requirements
- R1: Settings writes at BASE+4 set the header template, BASE+5 the stream ID, BASE+6 the trailer template, BASE+7 the entries per packet (0 is taken as 1, values above MAX_SPP as MAX_SPP), and BASE+8 the channel count (0 is taken as 1, values above MAXCH as MAXCH).
- R2: Every output word carries data in bits 31:0, start-of-packet in bit 32 and end-of-packet in bit 33, and has bits 35:34 at zero.
- R3: A packet is, in order: the header (start mark), the stream ID, time bits 63:32, time bits 31:0 of its first entry, the sample words, and the trailer template (end mark).
- R4: The header word carries template bits 31:16 and, in bits 15:0, the total number of words in the packet including header and trailer.
- R5: An input entry is {time[63:0], error, burst_end, samples}, with channel c in sample bits 32c+31:32c; each entry yields one word per active channel, channel 0 first.
- R6: A packet closes after the configured number of entries, and the next entry of the same burst opens a new packet with its own time stamp.
- R7: An entry with burst_end set is the last one in its packet, so a short burst gives one short packet.
- R8: An error entry yields one word with both marks set and the stream ID as data; if a packet is open, that packet is first closed with its trailer.
- R9: The output advances only on cycles with out_valid and out_ready high; while out_ready is low the word is held steady and no entry is lost.
- R10: No word of a packet reaches the output before the packet's trailer has been written.
- R11: buf_level counts the words held (including an unfinished packet); buf_empty is high when no finished word waits; buf_full is high when free space is below 5 + entries_per_packet*channels.
- R12: A clear pulse empties the buffer and drops any partly built packet, so buf_level is 0 and out_valid low on the next cycle.
- R13: A new packet or error entry is taken only while buf_full is low; in_ready is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Synchronous flush of buffer and partial packet |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | 8 | Settings address |
| cfg_wdata | input | 32 | Settings write data |
| in_entry | input | 66+32*MAXCH | Time, error flag, burst-end flag, samples |
| in_valid | input | 1 | Entry available |
| in_ready | output | 1 | Entry taken this cycle when in_valid is high |
| out_data | output | 36 | Framed output word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink accepts word |
| buf_level | output | $clog2(DEPTH)+1 | Words held in the buffer |
| buf_full | output | 1 | Too little room for another maximum packet |
| buf_empty | output | 1 | No finished word waiting |

## Verification
The properties assume the sink follows the valid/ready rule, that clear is never raised together with reset, and that settings change only while no packet is being built. The bench writes all settings between scenarios, after the previous traffic has fully drained. It pulses clear only while the output is stalled and no packet is visible, and it drops out_ready only at the falling edge. The frame-order property also relies on the design never exposing half a packet. So it is disabled during clear and restarts from the idle state afterwards.

// File: rtl/tsamp_framer.sv
module tsamp_framer #(
  parameter int BASE    = 0,
  parameter int MAXCH   = 2,
  parameter int MAX_SPP = 16,
  parameter int DEPTH   = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     cfg_we,
  input  logic [7:0]               cfg_addr,
  input  logic [31:0]              cfg_wdata,
  input  logic [66+32*MAXCH-1:0]   in_entry,
  input  logic                     in_valid,
  output logic                     in_ready,
  output logic [35:0]              out_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [$clog2(DEPTH):0]   buf_level,
  output logic                     buf_full,
  output logic                     buf_empty
);
  localparam int SW  = 32 * MAXCH;
  localparam int AW  = $clog2(DEPTH);
  localparam int LW  = AW + 1;
  localparam int CW  = $clog2(MAXCH + 1);
  localparam int SPW = $clog2(MAX_SPP + 1);
  localparam int PW  = $clog2(5 + MAX_SPP * MAXCH + 1);

  typedef enum logic [2:0] {S_IDLE, S_SID, S_THI, S_TLO, S_SAMP, S_WAIT, S_TRL, S_HDR} st_t;
  st_t st;

  logic [15:0]    hdr_hi;
  logic [31:0]    sid, trl;
  logic [SPW-1:0] spp;
  logic [CW-1:0]  nch;

  always_ff @(posedge clk)
    if (rst) begin
      hdr_hi <= '0; sid <= '0; trl <= '0;
      spp <= SPW'(1); nch <= CW'(1);
    end else if (cfg_we) begin
      if (cfg_addr == 8'(BASE + 4)) hdr_hi <= cfg_wdata[31:16];
      if (cfg_addr == 8'(BASE + 5)) sid <= cfg_wdata;
      if (cfg_addr == 8'(BASE + 6)) trl <= cfg_wdata;
      if (cfg_addr == 8'(BASE + 7))
        spp <= (cfg_wdata == 32'd0) ? SPW'(1) :
               (cfg_wdata > 32'(MAX_SPP)) ? SPW'(MAX_SPP) : cfg_wdata[SPW-1:0];
      if (cfg_addr == 8'(BASE + 8))
        nch <= (cfg_wdata == 32'd0) ? CW'(1) :
               (cfg_wdata > 32'(MAXCH)) ? CW'(MAXCH) : cfg_wdata[CW-1:0];
    end

  logic [33:0] mem [DEPTH];
  logic [LW-1:0] wptr, cptr, rptr, hptr;
  logic [LW-1:0] free;
  logic [PW-1:0] need, wc;

  logic [63:0]    e_time;
  logic [SW-1:0]  e_smp;
  logic           e_last;
  logic [CW-1:0]  ch;
  logic [SPW-1:0] cnt;

  wire            in_err  = in_entry[SW+1];
  wire            in_last = in_entry[SW];
  wire [63:0]     in_time = in_entry[SW+65:SW+2];
  wire [SW-1:0]   in_smp  = in_entry[SW-1:0];

  assign buf_level = wptr - rptr;
  assign free      = LW'(DEPTH) - buf_level;
  assign need      = PW'(5) + PW'(spp) * PW'(nch);
  assign buf_full  = 32'(free) < 32'(need);
  assign buf_empty = rptr == cptr;
  assign out_valid = !buf_empty;
  assign out_data  = {2'b00, mem[rptr[AW-1:0]]};

  assign in_ready = !clear && ((st == S_IDLE && !buf_full) || (st == S_WAIT && !in_err));
  wire take = in_valid && in_ready;
  wire last_ch = ch == nch - CW'(1);
  wire pkt_done = e_last || (cnt + SPW'(1) == spp);

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [33:0]   wr_word;

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = wptr[AW-1:0];
    wr_word = '0;
    unique case (st)
      S_IDLE: if (take && in_err) begin wr_en = 1'b1; wr_word = {2'b11, sid}; end
      S_SID:  begin wr_en = 1'b1; wr_word = {2'b00, sid}; end
      S_THI:  begin wr_en = 1'b1; wr_word = {2'b00, e_time[63:32]}; end
      S_TLO:  begin wr_en = 1'b1; wr_word = {2'b00, e_time[31:0]}; end
      S_SAMP: begin wr_en = 1'b1; wr_word = {2'b00, e_smp[32*ch +: 32]}; end
      S_TRL:  begin wr_en = 1'b1; wr_word = {2'b10, trl}; end
      S_HDR:  begin wr_en = 1'b1; wr_addr = hptr[AW-1:0]; wr_word = {2'b01, hdr_hi, 16'(wc)}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_word;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      st <= S_IDLE;
      wptr <= '0; cptr <= '0; rptr <= '0;
    end else begin
      if (out_valid && out_ready) rptr <= rptr + LW'(1);
      unique case (st)
        S_IDLE: if (take) begin
          wptr <= wptr + LW'(1);
          if (in_err) cptr <= wptr + LW'(1);
          else begin
            hptr <= wptr; e_time <= in_time; e_smp <= in_smp; e_last <= in_last;
            wc <= PW'(1); cnt <= '0; ch <= '0;
            st <= S_SID;
          end
        end
        S_SID, S_THI, S_TLO: begin
          wptr <= wptr + LW'(1);
          wc <= wc + PW'(1);
          st <= (st == S_SID) ? S_THI : (st == S_THI) ? S_TLO : S_SAMP;
        end
        S_SAMP: begin
          wptr <= wptr + LW'(1);
          wc <= wc + PW'(1);
          if (last_ch) begin
            ch <= '0;
            cnt <= cnt + SPW'(1);
            st <= pkt_done ? S_TRL : S_WAIT;
          end else ch <= ch + CW'(1);
        end
        S_WAIT: if (in_valid) begin
          if (in_err) st <= S_TRL;
          else begin
            e_smp <= in_smp; e_last <= in_last;
            st <= S_SAMP;
          end
        end
        S_TRL: begin
          wptr <= wptr + LW'(1);
          wc <= wc + PW'(1);
          st <= S_HDR;
        end
        S_HDR: begin
          cptr <= wptr;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsamp_framer_chk.sv
module tsamp_framer_chk #(
  parameter int DEPTH = 64
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   clear,
  input logic [35:0]            out_data,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [$clog2(DEPTH):0] buf_level,
  input logic                   buf_empty
);
  logic in_pkt;

  always_ff @(posedge clk)
    if (rst || clear) in_pkt <= 1'b0;
    else if (out_valid && out_ready) begin
      if (out_data[33]) in_pkt <= 1'b0;
      else if (out_data[32]) in_pkt <= 1'b1;
    end

  // R9
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !clear |=> out_valid && $stable(out_data));

  // R2
  a_r2_pad_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_data[35:34] == 2'b00);

  // R3
  a_r3_starts_marked: assert property (@(posedge clk) disable iff (rst || clear)
    out_valid && out_ready && !in_pkt |-> out_data[32]);

  // R3
  a_r3_no_restart: assert property (@(posedge clk) disable iff (rst || clear)
    out_valid && out_ready && in_pkt |-> !out_data[32]);

  // R11
  a_r11_level_bound: assert property (@(posedge clk) disable iff (rst)
    32'(buf_level) <= DEPTH);

  // R12
  a_r12_flush: assert property (@(posedge clk) disable iff (rst)
    clear |=> buf_level == '0 && buf_empty && !out_valid);
endmodule

bind tsamp_framer tsamp_framer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .clear(clear),
  .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
  .buf_level(buf_level), .buf_empty(buf_empty)
);

// File: tb/tsamp_framer_bench.sv
module tsamp_framer_bench;
  localparam int EW = 130;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clear = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [EW-1:0] in_entry;
  logic in_valid, in_ready;
  logic [35:0] out_data;
  logic out_valid, out_ready;
  logic [6:0] buf_level;
  logic buf_full, buf_empty;

  always #4 clk = ~clk;

  tsamp_framer u_tsamp_framer (
    .clk(clk), .rst(rst), .clear(clear),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_entry(in_entry), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .buf_level(buf_level), .buf_full(buf_full), .buf_empty(buf_empty)
  );

  int errors = 0, checks = 0;

  logic [EW-1:0] src_data [0:255];
  int src_n = 0, src_i = 0;
  assign in_valid = src_i < src_n;
  assign in_entry = src_data[src_i[7:0]];
  always @(posedge clk) if (in_valid && in_ready) src_i <= src_i + 1;

  logic rdy_base = 1'b0, toggle = 1'b0, phase = 1'b0;
  always @(negedge clk) phase <= ~phase;
  assign out_ready = rdy_base && (!toggle || phase);

  logic [35:0] got [0:511];
  int got_n = 0;
  always @(posedge clk) if (out_valid && out_ready) begin
    got[got_n[8:0]] <= out_data;
    got_n <= got_n + 1;
  end

  logic [35:0] exp_w [0:255];
  int exp_n;
  logic [31:0] c_hdr, c_sid, c_trl;
  int c_nch;

  function automatic logic [63:0] tm(int k);
    return {32'h0000_0100 + 32'(k), 32'hC000_0000 + 32'(k * 3)};
  endfunction
  function automatic logic [31:0] smp(int k, int c);
    return 32'hA000_0000 | (32'(c) << 20) | 32'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic set_cfg(input int off, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'(off); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input int k, input bit last, input bit err);
    src_data[src_n] = {tm(k), err, last, smp(k, 1), smp(k, 0)};
    src_n++;
  endtask

  task automatic add(input logic [35:0] w);
    exp_w[exp_n] = w; exp_n++;
  endtask

  task automatic exp_pkt(input int k0, input int n);
    logic [63:0] t = tm(k0);
    add({4'b0001, c_hdr[31:16], 16'(5 + n * c_nch)});
    add({4'b0000, c_sid});
    add({4'b0000, t[63:32]});
    add({4'b0000, t[31:0]});
    for (int k = k0; k < k0 + n; k++)
      for (int c = 0; c < c_nch; c++) add({4'b0000, smp(k, c)});
    add({4'b0010, c_trl});
  endtask

  task automatic verify(input string req, input int base);
    chk(got_n - base == exp_n, {req, " word count"}, 64'(got_n - base), 64'(exp_n));
    for (int i = 0; i < exp_n && base + i < got_n; i++)
      chk(got[base + i] == exp_w[i], req, 64'(got[base + i]), 64'(exp_w[i]));
  endtask

  task automatic drain(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!out_valid, "R13 reset out_valid", 64'(out_valid), 0);
    chk(buf_empty && buf_level == 0, "R11 reset empty", 64'(buf_level), 0);
    chk(in_ready && !buf_full, "R13 reset in_ready", 64'(in_ready), 1);
  endtask

  task automatic t_full_packets;
    int base;
    c_hdr = 32'h15F0_ABCD; c_sid = 32'hF00D_1234; c_trl = 32'hE000_0001; c_nch = 2;
    set_cfg(4, c_hdr); set_cfg(5, c_sid); set_cfg(6, c_trl);
    set_cfg(7, 4); set_cfg(8, 9);
    rdy_base = 1'b1; base = got_n; exp_n = 0;
    for (int k = 0; k < 8; k++) push(k, k == 7, 1'b0);
    exp_pkt(0, 4); exp_pkt(4, 4);
    drain(200);
    verify("R1 R2 R3 R4 R5 R6 full packets", base);
  endtask

  task automatic t_short;
    int base = got_n;
    exp_n = 0;
    for (int k = 10; k < 13; k++) push(k, k == 12, 1'b0);
    exp_pkt(10, 3);
    for (int k = 20; k < 25; k++) push(k, k == 24, 1'b0);
    exp_pkt(20, 4); exp_pkt(24, 1);
    drain(200);
    verify("R7 R6 short and overlong bursts", base);
    c_nch = 1; set_cfg(8, 1); set_cfg(7, 0);
    base = got_n; exp_n = 0;
    push(30, 1'b0, 1'b0); push(31, 1'b1, 1'b0);
    exp_pkt(30, 1); exp_pkt(31, 1);
    drain(100);
    verify("R1 zero entries per packet as one", base);
  endtask

  task automatic t_error;
    int base = got_n;
    set_cfg(7, 4);
    exp_n = 0;
    push(40, 1'b0, 1'b0); push(41, 1'b0, 1'b0); push(42, 1'b0, 1'b1);
    exp_pkt(40, 2); add({4'b0011, c_sid});
    push(43, 1'b0, 1'b1); add({4'b0011, c_sid});
    push(44, 1'b1, 1'b0); exp_pkt(44, 1);
    drain(150);
    verify("R8 error closes and marks", base);
  endtask

  task automatic t_backpressure;
    int base = got_n;
    logic [35:0] held;
    c_nch = 2; set_cfg(8, 2); set_cfg(7, 16);
    rdy_base = 1'b0; exp_n = 0;
    for (int k = 50; k < 70; k++) push(k, k == 69, 1'b0);
    exp_pkt(50, 16); exp_pkt(66, 4);
    drain(120);
    chk(buf_level == 37, "R11 level after one max packet", 64'(buf_level), 37);
    chk(buf_full && !buf_empty, "R11 full flag", 64'({buf_full, buf_empty}), 64'b10);
    chk(!in_ready && in_valid, "R13 entry held back", 64'(in_ready), 0);
    chk(out_valid && out_data == exp_w[0], "R9 first word waiting", 64'(out_data), 64'(exp_w[0]));
    held = out_data;
    drain(6);
    chk(out_data == held && out_valid, "R9 word stable while stalled", 64'(out_data), 64'(held));
    toggle = 1'b1; rdy_base = 1'b1;
    drain(300);
    toggle = 1'b0;
    verify("R9 no loss under stall", base);
  endtask

  task automatic t_clear;
    int base;
    set_cfg(7, 4);
    rdy_base = 1'b0;
    push(80, 1'b0, 1'b0); push(81, 1'b0, 1'b0);
    drain(30);
    chk(buf_level == 8, "R11 level counts open packet", 64'(buf_level), 8);
    chk(!out_valid && buf_empty, "R10 open packet hidden", 64'(out_valid), 0);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk(buf_level == 0 && buf_empty && !out_valid, "R12 flushed", 64'(buf_level), 0);
    rdy_base = 1'b1; base = got_n; exp_n = 0;
    push(82, 1'b1, 1'b0); exp_pkt(82, 1);
    drain(60);
    verify("R12 fresh packet after clear", base);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_full_packets();
    t_short();
    t_error();
    t_backpressure();
    t_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule